// File: doc/BRIEF.md
# Trigger Input Conditioning Bank

This block turns nine raw single-bit trigger sources into clean one-cycle pulses in the local clock domain. Each channel brings its source in through a synchronizer. Where the channel supports it, the source is then debounced. The block detects the rising edge of the resulting level and can hold the pulse back by a programmed number of cycles. Each channel is set up through its own 32-bit control word, written over a parallel write port.

The channels differ in what they support. Channels 0 and 3 treat the control word's auxiliary bit as a software trigger. On channels 4 to 7 that bit enables debouncing, and on channels 1 and 2 it has no effect. Channels 1 and 3 have no delay stage. Channel 8 is a placeholder whose output is tied low.

A set channel-reset bit parks the channel. It stays quiet and drops any pulse still waiting in its delay stage. Every channel leaves reset with this bit set, so software releases the channels one by one. Channels 4 to 7 also come out of reset with debounce enabled.

Top module: `trig_in_bank`

## Requirements
- R1: After the asynchronous reset, every control word has bit 31 set (channels 4 to 7 also have bit 30 set). No channel produces a pulse, whatever its source does, until its word is rewritten with bit 31 clear.
- R2: On a channel with debounce off and delay 0, a source that rises produces exactly one pulse of one cycle. The pulse appears at the third rising clock edge after the source changes. A falling source or a source held high produces no further pulse.
- R3: On channels 4 to 7 with bit 30 set, a new synchronized level is accepted only after it has held for 4 consecutive cycles. A source high for 3 cycles gives no pulse. An accepted rise pulses at the seventh edge after the source changes.
- R4: Control bits 4:0 give a delay d of 0 to 31 cycles on channels 0, 2 and 4 to 7. The pulse appears d cycles after the time it would have with delay 0.
- R5: Channels 1 and 3 ignore bits 4:0. Their pulses come at the delay-0 time for any value of that field.
- R6: On channels 0 and 3, a write that changes bit 30 from 0 to 1 issues one software pulse at the second edge after the write edge, plus the delay on channel 0. Rewriting 1 issues nothing. On these channels bit 30 does not debounce, and a 1-cycle source pulse still fires.
- R7: On channels 1 and 2, bit 30 has no effect. A 1-cycle source pulse with bit 30 set still gives exactly one pulse.
- R8: While a channel's bit 31 is set, its output stays low. A pulse already waiting in its delay stage is discarded and does not come out after release.
- R9: Channel 8 output is always 0.
- R10: A high cfg_we_i[i] at a clock edge loads cfg_wdata_i into channel i's word. Bits 29:5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_src_i | input | 9 | Raw trigger sources, one per channel |
| cfg_we_i | input | 9 | Per-channel control word write strobe |
| cfg_wdata_i | input | 32 | Control word: 31 reset, 30 auxiliary, 4:0 delay |
| trig_pulse_o | output | 9 | Conditioned one-cycle trigger pulses |

## Verification
A faulty synchronizer, debounce counter or delay tap shows up as a pulse that arrives one or more cycles away from its computed edge. It can also show as a pulse that is missing or extra. It is caught in the cycle where the expected and observed outputs first differ. A stale software-trigger history or a delay pipeline that was not cleared shows as an unexpected pulse. For the software trigger this happens two cycles after a write. For the delay pipeline it happens up to 31 cycles after a channel is released. The per-channel pulse count and arrival cycle for each channel variant expose which capability went wrong.

// File: rtl/trig_in_pkg.sv
package trig_in_pkg;
  localparam int CFG_W   = 32;
  localparam int RST_BIT = 31;
  localparam int AUX_BIT = 30;

  function automatic bit has_sw(int i);
    return (i == 0) || (i == 3);
  endfunction

  function automatic bit has_db(int i);
    return (i >= 4) && (i <= 7);
  endfunction

  function automatic bit has_dly(int i);
    return !((i == 1) || (i == 3));
  endfunction

  function automatic bit is_stub(int i);
    return i == 8;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_default(int i);
    logic [CFG_W-1:0] w;
    w = '0;
    w[RST_BIT] = 1'b1;
    w[AUX_BIT] = has_db(i);
    return w;
  endfunction
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/trig_debounce.sv
module trig_debounce #(
  parameter int HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic lvl_o
);
  localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (lvl_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      lvl_q <= lvl_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/trig_delay_line.sv
module trig_delay_line #(
  parameter int DLY_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ev_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             pulse_o
);
  localparam int DEPTH = 1 << DLY_W;

  logic [DEPTH-1:0] sr_q;
  logic [DLY_W-1:0] tap;
  logic             sel;
  logic             pulse_q;

  assign tap = dly_i - 1'b1;

  always_comb begin
    if (dly_i == '0) sel = ev_i;
    else             sel = sr_q[tap];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      pulse_q <= 1'b0;
    end else if (clr_i) begin
      sr_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      sr_q    <= {sr_q[DEPTH-2:0], ev_i};
      pulse_q <= sel;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/trig_in_chan.sv
module trig_in_chan #(
  parameter bit             HAS_SW      = 1'b0,
  parameter bit             HAS_DB      = 1'b0,
  parameter bit             HAS_DLY     = 1'b1,
  parameter int             DLY_W       = 5,
  parameter int             SYNC_STAGES = 2,
  parameter int             DB_HOLD     = 4,
  parameter bit             INIT_RST    = 1'b1,
  parameter bit             INIT_AUX    = 1'b0,
  parameter logic [DLY_W-1:0] INIT_DLY  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_i,
  input  logic             cfg_we_i,
  input  logic             cfg_rst_i,
  input  logic             cfg_aux_i,
  input  logic [DLY_W-1:0] cfg_dly_i,
  output logic             pulse_o
);
  logic             cfg_rst_q;
  logic             cfg_aux_q;
  logic [DLY_W-1:0] cfg_dly_q;
  logic             lvl_sync;
  logic             cond;
  logic             prev_q;
  logic             sw_rise;
  logic             ev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_rst_q <= INIT_RST;
      cfg_aux_q <= INIT_AUX;
      cfg_dly_q <= INIT_DLY;
    end else if (cfg_we_i) begin
      cfg_rst_q <= cfg_rst_i;
      cfg_aux_q <= cfg_aux_i;
      cfg_dly_q <= cfg_dly_i;
    end
  end

  trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (lvl_sync)
  );

  // auxiliary bit: software trigger wins over debounce if both are offered
  generate
    if (HAS_SW) begin : g_sw
      logic aux_prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) aux_prev_q <= INIT_AUX;
        else         aux_prev_q <= cfg_aux_q;
      end
      assign sw_rise = cfg_aux_q & ~aux_prev_q;
      assign cond    = lvl_sync;
    end else if (HAS_DB) begin : g_db
      logic lvl_db;
      trig_debounce #(.HOLD(DB_HOLD)) u_db (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (lvl_sync),
        .lvl_o (lvl_db)
      );
      assign cond    = cfg_aux_q ? lvl_db : lvl_sync;
      assign sw_rise = 1'b0;
    end else begin : g_plain
      logic unused_aux;
      assign unused_aux = cfg_aux_q;
      assign cond       = lvl_sync;
      assign sw_rise    = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cond;
  end

  assign ev = ((cond & ~prev_q) | sw_rise) & ~cfg_rst_q;

  generate
    if (HAS_DLY) begin : g_dly
      trig_delay_line #(.DLY_W(DLY_W)) u_dly (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cfg_rst_q),
        .ev_i   (ev),
        .dly_i  (cfg_dly_q),
        .pulse_o(pulse_o)
      );
    end else begin : g_nodly
      logic pulse_q;
      logic unused_dly;
      assign unused_dly = ^cfg_dly_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pulse_q <= 1'b0;
        else         pulse_q <= ev & ~cfg_rst_q;
      end
      assign pulse_o = pulse_q;
    end
  endgenerate
endmodule

// File: rtl/trig_in_bank.sv
module trig_in_bank
  import trig_in_pkg::*;
#(
  parameter int NUM_IN      = 9,
  parameter int DLY_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int DB_HOLD     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_IN-1:0] trig_src_i,
  input  logic [NUM_IN-1:0] cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [NUM_IN-1:0] trig_pulse_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^cfg_wdata_i[AUX_BIT-1:DLY_W];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_ch
    localparam logic [CFG_W-1:0] INIT = cfg_default(i);
    if (is_stub(i)) begin : g_stub
      logic unused_stub;
      assign unused_stub     = trig_src_i[i] ^ cfg_we_i[i];
      assign trig_pulse_o[i] = 1'b0;
    end else begin : g_live
      trig_in_chan #(
        .HAS_SW     (has_sw(i)),
        .HAS_DB     (has_db(i)),
        .HAS_DLY    (has_dly(i)),
        .DLY_W      (DLY_W),
        .SYNC_STAGES(SYNC_STAGES),
        .DB_HOLD    (DB_HOLD),
        .INIT_RST   (INIT[RST_BIT]),
        .INIT_AUX   (INIT[AUX_BIT]),
        .INIT_DLY   (INIT[DLY_W-1:0])
      ) u_chan (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .src_i    (trig_src_i[i]),
        .cfg_we_i (cfg_we_i[i]),
        .cfg_rst_i(cfg_wdata_i[RST_BIT]),
        .cfg_aux_i(cfg_wdata_i[AUX_BIT]),
        .cfg_dly_i(cfg_wdata_i[DLY_W-1:0]),
        .pulse_o  (trig_pulse_o[i])
      );
    end
  end
endmodule

// File: rtl/trig_in_bank_chk.sv
module trig_in_bank_chk
  import trig_in_pkg::*;
#(
  parameter int NUM_IN = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_IN-1:0] trig_src_i,
  input logic [NUM_IN-1:0] cfg_we_i,
  input logic [CFG_W-1:0]  cfg_wdata_i,
  input logic [NUM_IN-1:0] trig_pulse_o
);
  logic unused_src;
  assign unused_src = ^trig_src_i;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    localparam logic [CFG_W-1:0] INIT = cfg_default(i);
    logic rst_sh, aux_sh;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rst_sh <= INIT[RST_BIT];
        aux_sh <= INIT[AUX_BIT];
      end else if (cfg_we_i[i]) begin
        rst_sh <= cfg_wdata_i[RST_BIT];
        aux_sh <= cfg_wdata_i[AUX_BIT];
      end
    end

    // R8 / R1: parked channel stays low
    a_r8_reset_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rst_sh && $past(rst_sh)) |-> !trig_pulse_o[i]);

    if (is_stub(i)) begin : g_s
      a_r9_stub_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trig_pulse_o[i]);
    end else if (!has_sw(i)) begin : g_e
      a_r2_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_pulse_o[i] |=> !trig_pulse_o[i]);
    end else if (!has_dly(i)) begin : g_w
      a_r6_sw_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_we_i[i] && cfg_wdata_i[AUX_BIT] && !cfg_wdata_i[RST_BIT] && !aux_sh)
        |-> ##2 trig_pulse_o[i]);
    end
  end
endmodule

bind trig_in_bank trig_in_bank_chk #(.NUM_IN(NUM_IN)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trig_src_i  (trig_src_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .trig_pulse_o(trig_pulse_o)
);

// File: tb/trig_in_bank_tb_top.sv
module trig_in_bank_tb_top;
  localparam int CLK_P = 10;
  localparam int N = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic [N-1:0] we = '0;
  logic [31:0]  wdata = '0;
  logic [N-1:0] pulse;

  int checks = 0, fails = 0, cyc = 0, t0 = 0;
  int pcnt[N];
  int lastp[N];
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  trig_in_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_src_i(src),
    .cfg_we_i(we), .cfg_wdata_i(wdata), .trig_pulse_o(pulse)
  );

  function automatic bit cap_sw(int i);  return i == 0 || i == 3; endfunction
  function automatic bit cap_db(int i);  return i >= 4 && i <= 7; endfunction
  function automatic bit cap_dly(int i); return !(i == 1 || i == 3); endfunction

  // behavioural reference
  bit [N-1:0]  m_s1, m_s2, m_lvl, m_prev, m_swp, expv;
  int          m_cnt[N];
  bit [31:0]   m_cfg[N];
  bit [63:0]   m_pend[N];
  int          mc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_lvl = '0; m_prev = '0; m_swp = '0; expv = '0; mc = 0;
      for (int m = 0; m < N; m++) begin
        m_cnt[m] = 0; m_pend[m] = '0;
        m_cfg[m] = 32'h8000_0000 | (cap_db(m) ? 32'h4000_0000 : 32'h0);
      end
    end else begin
      for (int m = 0; m < N; m++) begin
        bit rb, aux, cond, ev, nxt;
        int d;
        rb = m_cfg[m][31]; aux = m_cfg[m][30];
        d = cap_dly(m) ? int'(m_cfg[m][4:0]) : 0;
        cond = (cap_db(m) && aux) ? m_lvl[m] : m_s2[m];
        ev = ((cond && !m_prev[m]) || (cap_sw(m) && aux && !m_swp[m])) && !rb;
        nxt = 0;
        if (rb) m_pend[m] = '0;
        else begin
          if (m_pend[m][mc % 64]) begin nxt = 1; m_pend[m][mc % 64] = 0; end
          if (ev) begin
            if (d == 0) nxt = 1;
            else m_pend[m][(mc + d) % 64] = 1;
          end
        end
        expv[m] = (m == 8) ? 1'b0 : nxt;
        if (m_s2[m] == m_lvl[m]) m_cnt[m] = 0;
        else if (m_cnt[m] == 3) begin m_lvl[m] = m_s2[m]; m_cnt[m] = 0; end
        else m_cnt[m]++;
        m_prev[m] = cond; m_swp[m] = aux;
        m_s2[m] = m_s1[m]; m_s1[m] = src[m];
        if (we[m]) m_cfg[m] = wdata;
      end
      mc++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_P/4);
    cyc++;
    if (rst_n) begin
      for (int m = 0; m < N; m++) begin
        chk(pulse[m] == expv[m], cur_req, pulse[m], expv[m], $sformatf("model ch%0d cyc%0d", m, cyc));
        if (pulse[m]) begin pcnt[m]++; lastp[m] = cyc; end
      end
    end
  end

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic clr(); for (int m = 0; m < N; m++) pcnt[m] = 0; endtask
  task automatic wr(int ch, logic [31:0] w);
    @(negedge clk); t0 = cyc; we = '0; we[ch] = 1'b1; wdata = w;
    @(negedge clk); we = '0;
  endtask
  task automatic rise(int ch); @(negedge clk); t0 = cyc; src[ch] = 1'b1; endtask
  task automatic fall(int ch); @(negedge clk); src[ch] = 1'b0; endtask
  task automatic blip(int ch, int len);
    @(negedge clk); t0 = cyc; src[ch] = 1'b1; idle(len); src[ch] = 1'b0;
  endtask

  int tot8 = 0;
  always @(posedge clk) begin #(CLK_P/4); if (pulse[8]) tot8++; end

  bit done = 0;
  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < N; m++) begin pcnt[m] = 0; lastp[m] = 0; end
    idle(3); rst_n = 1'b1;
    // R1 reset state
    chk(pulse == '0, "R1", pulse, 0, "outputs after reset");
    @(negedge clk); src = '1; idle(10); src = '0; idle(10);
    for (int m = 0; m < N; m++) chk(pcnt[m] == 0, "R1", pcnt[m], 0, $sformatf("ch%0d parked", m));

    // R2 plain edge, R10 write
    cur_req = "R2";
    wr(2, 32'h3fff_ffe0); clr(); rise(2); idle(10);
    chk(lastp[2] - t0 == 3, "R2", lastp[2] - t0, 3, "latency ch2");
    fall(2); idle(8);
    chk(pcnt[2] == 1, "R2", pcnt[2], 1, "one pulse per rise, none on fall");

    // R7 aux ignored on 1 and 2
    cur_req = "R7";
    wr(2, 32'h4000_0000); clr(); blip(2, 1); idle(8);
    chk(pcnt[2] == 1, "R7", pcnt[2], 1, "ch2 1-cycle source");
    chk(lastp[2] - t0 == 3, "R7", lastp[2] - t0, 3, "ch2 latency");
    wr(1, 32'h4000_0000); clr(); blip(1, 1); idle(8);
    chk(pcnt[1] == 1, "R7", pcnt[1], 1, "ch1 1-cycle source");

    // R3 debounce
    cur_req = "R3";
    wr(4, 32'h4000_0000); clr(); blip(4, 3); idle(12);
    chk(pcnt[4] == 0, "R3", pcnt[4], 0, "3-cycle glitch rejected");
    rise(4); idle(12);
    chk(pcnt[4] == 1, "R3", pcnt[4], 1, "held level accepted");
    chk(lastp[4] - t0 == 7, "R3", lastp[4] - t0, 7, "debounced latency");
    fall(4); idle(12);

    // R4 delay
    cur_req = "R4";
    wr(6, 32'h0000_0005); clr(); rise(6); idle(14);
    chk(lastp[6] - t0 == 8, "R4", lastp[6] - t0, 8, "ch6 delay 5");
    fall(6);
    wr(5, 32'h4000_0003); clr(); rise(5); idle(16);
    chk(lastp[5] - t0 == 10, "R4", lastp[5] - t0, 10, "ch5 debounce+delay 3");
    fall(5);
    wr(0, 32'h0000_0007); clr(); rise(0); idle(14);
    chk(lastp[0] - t0 == 10, "R4", lastp[0] - t0, 10, "ch0 delay 7");
    chk(pcnt[0] == 1, "R4", pcnt[0], 1, "ch0 single pulse");
    fall(0); idle(6);

    // R5 delay ignored
    cur_req = "R5";
    wr(1, 32'h0000_001f); clr(); rise(1); idle(10);
    chk(lastp[1] - t0 == 3, "R5", lastp[1] - t0, 3, "ch1 ignores delay");
    fall(1);
    wr(3, 32'h0000_001f); clr(); rise(3); idle(10);
    chk(lastp[3] - t0 == 3, "R5", lastp[3] - t0, 3, "ch3 ignores delay");
    fall(3); idle(6);

    // R6 software trigger
    cur_req = "R6";
    clr(); wr(3, 32'h4000_001f); idle(6);
    chk(lastp[3] - t0 == 2, "R6", lastp[3] - t0, 2, "ch3 sw latency");
    wr(3, 32'h4000_001f); idle(6);
    chk(pcnt[3] == 1, "R6", pcnt[3], 1, "rewrite of 1 silent");
    wr(3, 32'h0000_001f); wr(3, 32'h4000_001f); idle(6);
    chk(pcnt[3] == 2, "R6", pcnt[3], 2, "re-armed sw trigger");
    blip(3, 1); idle(8);
    chk(pcnt[3] == 3, "R6", pcnt[3], 3, "no debounce on sw channel");
    clr(); wr(0, 32'h4000_0007); idle(14);
    chk(lastp[0] - t0 == 9, "R6", lastp[0] - t0, 9, "ch0 sw with delay 7");
    chk(pcnt[0] == 1, "R6", pcnt[0], 1, "ch0 sw single pulse");

    // R8 channel reset flushes delay
    cur_req = "R8";
    wr(6, 32'h0000_0014); clr(); rise(6); idle(5);
    wr(6, 32'h8000_0014); idle(30);
    chk(pcnt[6] == 0, "R8", pcnt[6], 0, "pending pulse discarded");
    fall(6); idle(4); rise(6); idle(8);
    chk(pcnt[6] == 0, "R8", pcnt[6], 0, "parked ignores source");
    fall(6); idle(4); wr(6, 32'h0000_0014); idle(30);
    chk(pcnt[6] == 0, "R8", pcnt[6], 0, "no late pulse after release");

    // R9 stub
    cur_req = "R9";
    wr(8, 32'h4000_0000); blip(8, 5); idle(4); rise(8); idle(6); fall(8); idle(4);
    chk(tot8 == 0, "R9", tot8, 0, "ch8 never pulses");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule